// File: doc/BRIEF.md
# Startup Reset Sequencer with Clock-Lock Gating

This block turns two untimed start-up events into a clean reset for the state machines of a clocked domain. One input rises when the device stops holding its storage at initial values. The other is the lock indication of an on-chip clock manager. Neither input is related to the system clock, so each passes through its own multi-stage synchronizer before any decision uses it.

Once the synchronized release is seen, the block drives a fixed-length reset pulse to the clock manager. A manager with external feedback needs this reset after configuration to lock reliably. The block then holds the downstream reset until the synchronized lock has stayed high for a settling window of 15 cycles. If lock is lost at any later time, for example because the clock manager was reset again, the downstream reset comes back at once and the settling window starts over.

If the release input falls, the sequence returns to its idle state. The next release issues a new clock-manager pulse.

Top module: `startup_reset_seq`

## Requirements
- R1: While rst_ni is low, sys_rst_o is 1 and cm_rst_o is 0.
- R2: After cfg_done_i rises (and stays high), cm_rst_o rises on the third rising clock edge. Two edges are used by the synchronizer and one by the registered output.
- R3: With cfg_done_i held high, cm_rst_o stays high for exactly PULSE_CYC (default 3) consecutive cycles, and only once per release.
- R4: sys_rst_o is 1 in every cycle in which cm_rst_o is 1.
- R5: Suppose the synchronized lock stays high for SETTLE_CNT (default 15) consecutive cycles after the pulse ends. Then sys_rst_o falls at the edge after the fifteenth of those cycles, and never falls earlier.
- R6: If the synchronized lock drops while the block is settling, the settling count restarts from zero.
- R7: A lock_i drop seen at run time (after the two-stage synchronizer) sets sys_rst_o to 1 on the edge at which the synchronized lock is first sampled low. Release then needs a full new settling window.
- R8: When the synchronized cfg_done_i falls, sys_rst_o goes to 1 and cm_rst_o goes to 0 at the next edge. A later rise of cfg_done_i issues a new pulse as in R2 and R3.
- R9: lock_i has no effect on cm_rst_o. cm_rst_o is 1 only inside the pulse that follows a release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System / reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the sequencer itself |
| cfg_done_i | input | 1 | Asynchronous level, high once initial values are released |
| lock_i | input | 1 | Asynchronous clock-manager lock indication |
| cm_rst_o | output | 1 | Registered active-high reset pulse to the clock manager |
| sys_rst_o | output | 1 | Registered active-high reset for downstream logic |

## Verification
A directed release with lock already high pins down the exact pulse latency and the exact release edge of the settling window. A lock glitch inside the window shows the difference between restarting the count and merely pausing it. A lock drop during run shows whether reset reassertion is immediate or waits for settling. A release that falls mid-pulse shows whether a second pulse is issued. Long random runs then toggle lock with hold times both shorter and longer than the window, and drop the release at random. This separates designs that count total lock-high cycles from those that require consecutive ones.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PULSE  = 2'd1,
    ST_SETTLE = 2'd2,
    ST_RUN    = 2'd3
  } seq_state_e;
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= 1'b0;
    else         stage_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= 1'b0;
      else         stage_q[g] <= stage_q[g-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/srs_counter.sv
module srs_counter #(
  parameter int LIMIT = 15,
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == W'(LIMIT - 1));
endmodule

// File: rtl/startup_reset_seq.sv
module startup_reset_seq #(
  parameter int SYNC_STAGES = 2,
  parameter int PULSE_CYC   = 3,
  parameter int SETTLE_CNT  = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_done_i,
  input  logic lock_i,
  output logic cm_rst_o,
  output logic sys_rst_o
);
  import srs_pkg::*;

  localparam int PW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
  localparam int SW = (SETTLE_CNT > 1) ? $clog2(SETTLE_CNT) : 1;

  logic cfg_s, lock_s;
  seq_state_e state_q, state_d;
  logic p_clr, p_en, p_last;
  logic s_clr, s_en, s_last;
  logic [PW-1:0] p_cnt;
  logic [SW-1:0] s_cnt;
  logic cm_rst_q, sys_rst_q;

  srs_sync #(.STAGES(SYNC_STAGES)) i_cfg_sync (
    .clk_i, .rst_ni, .d_i(cfg_done_i), .q_o(cfg_s)
  );

  srs_sync #(.STAGES(SYNC_STAGES)) i_lock_sync (
    .clk_i, .rst_ni, .d_i(lock_i), .q_o(lock_s)
  );

  srs_counter #(.LIMIT(PULSE_CYC)) i_pulse_cnt (
    .clk_i, .rst_ni, .clr_i(p_clr), .en_i(p_en), .cnt_o(p_cnt), .last_o(p_last)
  );

  srs_counter #(.LIMIT(SETTLE_CNT)) i_settle_cnt (
    .clk_i, .rst_ni, .clr_i(s_clr), .en_i(s_en), .cnt_o(s_cnt), .last_o(s_last)
  );

  always_comb begin
    state_d = state_q;
    p_clr   = 1'b0;
    p_en    = 1'b0;
    s_clr   = 1'b0;
    s_en    = 1'b0;
    if (!cfg_s) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_d = ST_PULSE;
          p_clr   = 1'b1;
        end
        ST_PULSE: begin
          if (p_last) begin
            state_d = ST_SETTLE;
            s_clr   = 1'b1;
          end else begin
            p_en = 1'b1;
          end
        end
        ST_SETTLE: begin
          // consecutive lock-high cycles only
          if (!lock_s)     s_clr = 1'b1;
          else if (s_last) state_d = ST_RUN;
          else             s_en = 1'b1;
        end
        ST_RUN: begin
          if (!lock_s) begin
            state_d = ST_SETTLE;
            s_clr   = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cm_rst_q  <= 1'b0;
      sys_rst_q <= 1'b1;
    end else begin
      state_q   <= state_d;
      cm_rst_q  <= (state_d == ST_PULSE);
      sys_rst_q <= (state_d != ST_RUN);
    end
  end

  assign cm_rst_o  = cm_rst_q;
  assign sys_rst_o = sys_rst_q;

  logic unused_cnt;
  assign unused_cnt = ^{p_cnt, s_cnt};
endmodule

// File: rtl/srs_chk.sv
module srs_chk #(
  parameter int PULSE_CYC  = 3,
  parameter int SETTLE_CNT = 15
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cfg_s_i,
  input logic lock_s_i,
  input logic cm_rst_i,
  input logic sys_rst_i
);
  logic       armed = 1'b0;
  logic [7:0] pulse_len;
  logic [7:0] lock_run;

  always_ff @(posedge clk_i) armed <= 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_len <= '0;
      lock_run  <= '0;
    end else begin
      pulse_len <= cm_rst_i ? ((pulse_len == 8'hff) ? pulse_len : pulse_len + 1'b1) : '0;
      lock_run  <= lock_s_i ? ((lock_run == 8'hff) ? lock_run : lock_run + 1'b1) : '0;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    (armed && !rst_ni) |-> (sys_rst_i && !cm_rst_i));

  // R2
  pulse_after_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cm_rst_i) |-> $past(cfg_s_i));

  // R3
  pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cm_rst_i) && $past(cfg_s_i)) |-> (pulse_len == 8'(PULSE_CYC)));

  // R3
  pulse_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_len <= 8'(PULSE_CYC));

  // R4
  sys_during_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cm_rst_i |-> sys_rst_i);

  // R5
  settle_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_i) |-> (lock_run >= 8'(SETTLE_CNT)));

  // R7
  lock_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_s_i |=> sys_rst_i);

  // R8
  cfg_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_s_i |=> (sys_rst_i && !cm_rst_i));
endmodule

bind startup_reset_seq srs_chk #(
  .PULSE_CYC (PULSE_CYC),
  .SETTLE_CNT(SETTLE_CNT)
) i_srs_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cfg_s_i  (cfg_s),
  .lock_s_i (lock_s),
  .cm_rst_i (cm_rst_o),
  .sys_rst_i(sys_rst_o)
);

// File: tb/test_startup_reset_seq.sv
module test_startup_reset_seq;
  localparam int CLK_PERIOD = 10;
  localparam int P = 3;
  localparam int S = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg = 1'b0;
  logic lock = 1'b0;
  logic cm_rst, sys_rst;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  startup_reset_seq i_startup_reset_seq (
    .clk_i(clk), .rst_ni(rst_n), .cfg_done_i(cfg), .lock_i(lock),
    .cm_rst_o(cm_rst), .sys_rst_o(sys_rst)
  );

  // behavioural expectation: 0 idle, 1 pulse, 2 settle, 3 run
  logic m_c1, m_c2, m_l1, m_l2;
  int   m_ph, m_pc, m_sc;
  string tag_cm, tag_sys;

  function automatic void model_reset();
    m_c1 = 0; m_c2 = 0; m_l1 = 0; m_l2 = 0;
    m_ph = 0; m_pc = 0; m_sc = 0;
  endfunction

  function automatic void model_step(logic c_in, logic l_in);
    logic cs, ls;
    int   prev;
    cs = m_c2; ls = m_l2;
    m_c2 = m_c1; m_c1 = c_in; m_l2 = m_l1; m_l1 = l_in;
    prev = m_ph;
    if (!cs) m_ph = 0;
    else case (m_ph)
      0: begin m_ph = 1; m_pc = 0; end
      1: if (m_pc == P-1) begin m_ph = 2; m_sc = 0; end else m_pc++;
      2: if (!ls) m_sc = 0; else if (m_sc == S-1) m_ph = 3; else m_sc++;
      default: if (!ls) begin m_ph = 2; m_sc = 0; end
    endcase
    tag_cm  = (m_ph == 1) ? ((m_pc == 0) ? "R2" : "R3") : "R9";
    if (m_ph == 0)                    tag_sys = "R8";
    else if (m_ph == 1)               tag_sys = "R4";
    else if (!ls && prev == 3)        tag_sys = "R7";
    else if (!ls && prev == 2)        tag_sys = "R6";
    else                              tag_sys = "R5";
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one clock: inputs are already driven, compare at the next falling edge
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    model_step(cfg, lock);
    chk(tag_cm,  "cm_rst_o",  cm_rst,  (m_ph == 1));
    chk(tag_sys, "sys_rst_o", sys_rst, (m_ph != 3));
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int lat;
    void'($urandom(32'h1a2b3c4d));
    model_reset();
    cfg = 1'b1; lock = 1'b1;
    // R1: reset holds outputs
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R1", "sys_rst_o", sys_rst, 1'b1);
      chk("R1", "cm_rst_o",  cm_rst,  1'b0);
    end
    cfg = 1'b0;
    rst_n = 1'b1;
    run(3);

    // R2: pulse latency of three edges from release
    cfg = 1'b1;
    lat = 0;
    for (int i = 0; i < 10 && !cm_rst; i++) begin cyc(); lat++; end
    chk("R2", "pulse latency==3", (lat == 3), 1'b1);
    // R3 / R5: pulse of P then settle window of S with lock held high
    lat = 1;
    while (cm_rst && lat < 20) begin cyc(); lat++; end
    chk("R3", "pulse length==P", (lat - 1 == P), 1'b1);
    lat = 0;
    while (sys_rst && lat < 60) begin cyc(); lat++; end
    chk("R5", "settle cycles==S", (lat == S), 1'b1);

    // R7: lock loss during run, reassert on third edge
    lock = 1'b0;
    lat = 0;
    while (!sys_rst && lat < 10) begin cyc(); lat++; end
    chk("R7", "reassert latency==3", (lat == 3), 1'b1);
    run(4);
    // R6: glitch mid-settle restarts count
    lock = 1'b1; run(10);
    lock = 1'b0; run(1);
    lock = 1'b1; run(S + 4);
    chk("R6", "released after restart", sys_rst, 1'b0);
    // R9: lock toggles do not touch cm_rst_o
    lock = 1'b0; run(3); lock = 1'b1; run(3);
    chk("R9", "cm_rst_o quiet", cm_rst, 1'b0);

    // R8: release drop mid-pulse, then a fresh pulse
    cfg = 1'b0; run(5);
    cfg = 1'b1; run(4);
    cfg = 1'b0; run(5);
    chk("R8", "sys_rst_o after drop", sys_rst, 1'b1);
    cfg = 1'b1; run(4);
    chk("R8", "new pulse", cm_rst, 1'b1);
    run(30);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 299) == 0) begin
        cfg = 1'b0;
        run($urandom_range(1, 10));
        cfg = 1'b1;
      end
      if (lock) begin
        if ($urandom_range(0, 19) == 0) lock = 1'b0;
      end else begin
        if ($urandom_range(0, 3) == 0) lock = 1'b1;
      end
      cyc();
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule